// File: doc/BRIEF.md
# Dual Down-Counting Reload Timer

This peripheral holds two independent down-counters behind a word-wide register port. Each counter has its own enable, auto-reload enable, tick-source select and power-of-two prescaler, all kept in one shared control word. A counter that is enabled decrements once per tick. A tick comes either from the system clock through the prescaler, or from an external fixed-reference strobe.

When a counter is at zero and receives a tick, it expires. With auto-reload set, it restarts from its reload register. This gives a periodic event once every reload+1 ticks. Loading all ones into both registers turns it into a free-running wrapping counter, and software can read that counter inverted to get an up-counting timestamp. With auto-reload clear, the counter runs once and then parks at zero.

Every expiry sets a sticky flag in a shared status word. Each flag drives its own interrupt line as a level. Software clears a flag by writing zero to that flag's bit.

Top module: `dual_reload_timer`

## Requirements
- R1: After reset, every register reads zero and both irq lines are low.
- R2: Register byte offsets: control 0x00, status 0x04, reload0 0x10, value0 0x14, reload1 0x18, value1 0x1C. Writes to control, reload and value registers read back unchanged in their defined bits. Any other offset reads zero.
- R3: Control bit 0 enables counter 0 and bit 2 enables counter 1. An enabled counter decrements by one per tick. With auto-reload set (bit 1 for counter 0, bit 3 for counter 1), a tick at zero loads the reload value, so expiries come every reload+1 ticks.
- R4: Control bits 21:19 (counter 0) and 24:22 (counter 1) hold a prescaler value N. With the clock-sourced tick, the counter ticks once every 2^N clocks.
- R5: With auto-reload clear, the counter expires once on the tick at zero and then holds zero. It expires again only after its value register is rewritten.
- R6: Status bit 0 is counter 0's expiry flag and bit 8 is counter 1's. A status write with 0 in a flag's bit clears that flag. A 1 in that bit leaves the flag unchanged.
- R7: Control bit 11 (counter 0) and bit 12 (counter 1) select the ref_tick strobe as the tick source. When selected, the counter ticks once per clock in which ref_tick is high, and the prescaler is bypassed.
- R8: A write to a value register takes effect at that clock edge and restarts that counter's prescaler phase. With prescaler N, the next decrement comes 2^N clocks after the write.
- R9: With all ones in the reload register, a counter passes from zero to 0xFFFFFFFF and keeps counting down.
- R10: The two counters are independent. A disabled counter keeps its value while the other one runs.
- R11: irq[i] equals counter i's expiry flag. When an expiry and a clearing write fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_tick | input | 1 | Fixed-reference tick strobe, one clock wide |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 6 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq | output | 2 | Per-counter interrupt level |

## Verification
Several properties are checked on every cycle:
- a decrement is exactly one per tick;
- a parked one-shot counter stays at zero;
- no tick is produced while a counter is disabled;
- an expiry always leaves its flag set, even against a clearing write;
- writing a 1 never clears a flag.

Other behaviours only the bench scenarios can show:
- expiry period as a function of the reload value and the prescaler (swept over small reloads and every low prescaler setting);
- the ref_tick source;
- the exact clock at which a value write restarts the prescaler phase;
- the wrap to all ones;
- independence of the two counters.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 6;
  localparam int NCH     = 2;
  localparam int DIV_W   = 3;
  localparam int PRE_W   = (1 << DIV_W) - 1;

  localparam logic [ADDR_W-1:0] OFS_CTRL   = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_STAT   = 6'h04;
  localparam logic [ADDR_W-1:0] OFS_RLD0   = 6'h10;
  localparam logic [ADDR_W-1:0] OFS_VAL0   = 6'h14;
  localparam logic [ADDR_W-1:0] OFS_RLD1   = 6'h18;
  localparam logic [ADDR_W-1:0] OFS_VAL1   = 6'h1C;

  // control word field positions, indexed by channel
  function automatic int en_bit(input int ch);
    return 2 * ch;
  endfunction
  function automatic int rl_bit(input int ch);
    return 2 * ch + 1;
  endfunction
  function automatic int ref_bit(input int ch);
    return 11 + ch;
  endfunction
  function automatic int div_lsb(input int ch);
    return 19 + DIV_W * ch;
  endfunction
  function automatic int flag_bit(input int ch);
    return 8 * ch;
  endfunction

  // terminal count of the prescaler for a division exponent
  function automatic logic [PRE_W-1:0] pre_limit(input logic [DIV_W-1:0] div);
    return PRE_W'((1 << div) - 1);
  endfunction

  typedef struct packed {
    logic             en;
    logic             reload_en;
    logic             ref_sel;
    logic [DIV_W-1:0] div;
  } chan_cfg_t;
endpackage

// File: rtl/timer_prescale.sv
module timer_prescale
  import dtmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  chan_cfg_t        cfg,
  input  logic             restart,
  input  logic             ref_tick,
  output logic             tick
);
  logic [PRE_W-1:0] phase;
  logic             clk_tick;

  assign clk_tick = cfg.en && (phase == pre_limit(cfg.div));
  assign tick     = cfg.en && (cfg.ref_sel ? ref_tick : clk_tick);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      phase <= '0;
    else if (restart || !cfg.en || cfg.ref_sel || clk_tick)
      phase <= '0;
    else
      phase <= phase + 1'b1;
  end

  a_r4_no_tick_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.en |-> !tick);
endmodule

// File: rtl/timer_count_unit.sv
module timer_count_unit
  import dtmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  chan_cfg_t         cfg,
  input  logic              tick,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  input  logic [DATA_W-1:0] reload_val,
  output logic [DATA_W-1:0] count,
  output logic              expire
);
  logic armed;
  logic at_zero;

  assign at_zero = (count == '0);
  assign expire  = !load && tick && at_zero && (cfg.reload_en || armed);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      armed <= 1'b0;
    end else if (load) begin
      count <= load_val;
      armed <= 1'b1;
    end else if (tick) begin
      if (!at_zero) begin
        count <= count - 1'b1;
      end else if (expire) begin
        if (cfg.reload_en) begin
          count <= reload_val;
          armed <= 1'b1;
        end else begin
          armed <= 1'b0;
        end
      end
    end
  end

  a_r3_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && !at_zero) |=> (count == $past(count) - 1'b1));
  a_r5_parked_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && at_zero && !cfg.reload_en && !armed) |=> (count == '0));
endmodule

// File: rtl/timer_event_flags.sv
module timer_event_flags
  import dtmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    expire,
  input  logic              stat_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [NCH-1:0]    flags
);
  logic [NCH-1:0] clr;

  for (genvar i = 0; i < NCH; i++) begin : g_flag
    assign clr[i] = stat_wr && !wdata[flag_bit(i)];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        flags[i] <= 1'b0;
      else if (expire[i])
        flags[i] <= 1'b1;
      else if (clr[i])
        flags[i] <= 1'b0;
    end

    a_r11_expiry_wins: assert property (@(posedge clk) disable iff (!rst_n)
      expire[i] |=> flags[i]);
    a_r6_one_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_wr && wdata[flag_bit(i)] && flags[i]) |=> flags[i]);
  end
endmodule

// File: rtl/dual_reload_timer.sv
module dual_reload_timer
  import dtmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NCH-1:0]    irq
);
  chan_cfg_t         cfg   [NCH];
  logic [DATA_W-1:0] rld   [NCH];
  logic [DATA_W-1:0] cnt   [NCH];
  logic [NCH-1:0]    tick;
  logic [NCH-1:0]    load;
  logic [NCH-1:0]    expire;
  logic [NCH-1:0]    flags;
  logic              ctrl_wr;
  logic              stat_wr;
  logic [DATA_W-1:0] ctrl_word;
  logic [DATA_W-1:0] stat_word;

  assign ctrl_wr = bus_wr && (bus_addr == OFS_CTRL);
  assign stat_wr = bus_wr && (bus_addr == OFS_STAT);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam logic [ADDR_W-1:0] RLD_A = (i == 0) ? OFS_RLD0 : OFS_RLD1;
    localparam logic [ADDR_W-1:0] VAL_A = (i == 0) ? OFS_VAL0 : OFS_VAL1;

    assign load[i] = bus_wr && (bus_addr == VAL_A);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg[i] <= '0;
        rld[i] <= '0;
      end else begin
        if (ctrl_wr) begin
          cfg[i].en        <= bus_wdata[en_bit(i)];
          cfg[i].reload_en <= bus_wdata[rl_bit(i)];
          cfg[i].ref_sel   <= bus_wdata[ref_bit(i)];
          cfg[i].div       <= bus_wdata[div_lsb(i) +: DIV_W];
        end
        if (bus_wr && (bus_addr == RLD_A))
          rld[i] <= bus_wdata;
      end
    end

    timer_prescale u_pre (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg      (cfg[i]),
      .restart  (load[i]),
      .ref_tick (ref_tick),
      .tick     (tick[i])
    );

    timer_count_unit u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg        (cfg[i]),
      .tick       (tick[i]),
      .load       (load[i]),
      .load_val   (bus_wdata),
      .reload_val (rld[i]),
      .count      (cnt[i]),
      .expire     (expire[i])
    );
  end

  timer_event_flags u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .expire  (expire),
    .stat_wr (stat_wr),
    .wdata   (bus_wdata),
    .flags   (flags)
  );

  assign irq = flags;

  always_comb begin
    ctrl_word = '0;
    stat_word = '0;
    for (int i = 0; i < NCH; i++) begin
      ctrl_word[en_bit(i)]             = cfg[i].en;
      ctrl_word[rl_bit(i)]             = cfg[i].reload_en;
      ctrl_word[ref_bit(i)]            = cfg[i].ref_sel;
      ctrl_word[div_lsb(i) +: DIV_W]   = cfg[i].div;
      stat_word[flag_bit(i)]           = flags[i];
    end
  end

  always_comb begin
    case (bus_addr)
      OFS_CTRL: bus_rdata = ctrl_word;
      OFS_STAT: bus_rdata = stat_word;
      OFS_RLD0: bus_rdata = rld[0];
      OFS_VAL0: bus_rdata = cnt[0];
      OFS_RLD1: bus_rdata = rld[1];
      OFS_VAL1: bus_rdata = cnt[1];
      default:  bus_rdata = '0;
    endcase
  end

  a_r10_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg[1].en && !load[1]) |=> $stable(cnt[1]));
endmodule

// File: tb/dual_reload_timer_test.sv
`timescale 1ns/1ps
module dual_reload_timer_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        ref_tick = 0;
  logic        bus_wr = 0;
  logic [5:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic [1:0]  irq;

  int tests = 0, fails = 0;
  int cyc = 0;
  int ref_cnt = 0;
  bit ref_on = 0;
  bit done = 0;

  dual_reload_timer uut (.*);

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // reference strobe: high one clock in every three
  always @(negedge clk) begin
    if (ref_on) begin
      ref_cnt  <= (ref_cnt == 2) ? 0 : ref_cnt + 1;
      ref_tick <= (ref_cnt == 2);
    end else begin
      ref_tick <= 0;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 0;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; #1;
    d = bus_rdata;
  endtask

  function automatic logic [31:0] ctl(int ch, bit en, bit rl, bit rs, int div);
    logic [31:0] c = 0;
    c[2*ch] = en; c[2*ch+1] = rl; c[11+ch] = rs;
    c[19+3*ch +: 3] = div[2:0];
    return c;
  endfunction

  // waits for irq[ch] to be high at a negedge, returns cycle, clears it
  task automatic catch_irq(int ch, output int at);
    int lim = 0;
    do begin @(negedge clk); lim++; end while (!irq[ch] && lim < 5000);
    at = cyc;
    wr(6'h04, ch == 0 ? 32'hFFFF_FFFE : 32'hFFFF_FEFF);
  endtask

  task automatic measure(string req, int ch, int rl, int div, bit rs, int exp_per);
    int t0, t1, t2;
    wr(6'h00, 0);
    wr(6'h04, 0);
    wr(ch == 0 ? 6'h10 : 6'h18, rl);
    wr(ch == 0 ? 6'h14 : 6'h1C, rl);
    wr(6'h00, ctl(ch, 1, 1, rs, div));
    catch_irq(ch, t0);
    catch_irq(ch, t1);
    catch_irq(ch, t2);
    check(req, t2 - t1, exp_per);
    check(req, t1 - t0, exp_per);
  endtask

  initial begin
    #2_000_000;
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int t;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    foreach (d[i]) ;
    for (int a = 0; a < 64; a += 4) begin
      rd(a[5:0], d);
      check("R1", d, 0);
    end
    check("R1", {30'b0, irq}, 0);

    // R2 readback
    wr(6'h10, 32'hA5A5_1234); rd(6'h10, d); check("R2", d, 32'hA5A5_1234);
    wr(6'h18, 32'h0BAD_F00D); rd(6'h18, d); check("R2", d, 32'h0BAD_F00D);
    wr(6'h14, 32'h1111_2222); rd(6'h14, d); check("R2", d, 32'h1111_2222);
    wr(6'h1C, 32'h3333_4444); rd(6'h1C, d); check("R2", d, 32'h3333_4444);
    wr(6'h00, 32'hFFFF_FFF0 & ~ctl(0, 1, 1, 0, 0) & ~ctl(1, 1, 1, 0, 0));
    rd(6'h00, d); check("R2", d, ctl(0, 0, 0, 1, 7) | ctl(1, 0, 0, 1, 7));
    wr(6'h20, 32'hFFFF_FFFF); rd(6'h20, d); check("R2", d, 0);
    wr(6'h00, 0);

    // R10: counter 1 disabled keeps its value while counter 0 runs
    wr(6'h1C, 32'h0000_0777);
    wr(6'h14, 32'h0000_0100);
    wr(6'h00, ctl(0, 1, 0, 0, 0));
    repeat (20) @(negedge clk);
    rd(6'h1C, d); check("R10", d, 32'h0000_0777);
    rd(6'h14, d); check("R10", d < 32'h100 ? 32'd1 : 32'd0, 1);

    // R3/R4 sweep: periodic expiry spacing = (reload+1) << div
    for (int ch = 0; ch < 2; ch++)
      for (int div = 0; div < 4; div++)
        for (int rl = 2; rl < 6; rl++)
          measure(ch == 0 ? "R3/R4 ch0" : "R3/R4 ch1", ch, rl, div, 0,
                  (rl + 1) << div);

    // R7 reference strobe source, prescaler bypassed
    ref_on = 1;
    measure("R7 ch0", 0, 3, 5, 1, 12);
    measure("R7 ch1", 1, 4, 2, 1, 15);
    ref_on = 0;

    // R5 one-shot
    wr(6'h00, 0); wr(6'h04, 0);
    wr(6'h14, 5);
    wr(6'h00, ctl(0, 1, 0, 0, 0));
    repeat (12) @(negedge clk);
    check("R5 flag", {31'b0, irq[0]}, 1);
    rd(6'h14, d); check("R5 holds", d, 0);
    wr(6'h04, 32'hFFFF_FFFE);
    repeat (20) @(negedge clk);
    check("R5 no refire", {31'b0, irq[0]}, 0);
    wr(6'h14, 2);
    repeat (8) @(negedge clk);
    check("R5 rearm", {31'b0, irq[0]}, 1);

    // R6 write-one keeps, write-zero clears
    wr(6'h04, 32'hFFFF_FFFF);
    rd(6'h04, d); check("R6 keep", d, 32'h1);
    wr(6'h04, 32'h0000_0100);
    rd(6'h04, d); check("R6 clear", d, 0);
    check("R11 irq level", {30'b0, irq}, 0);

    // R11 expiry beats clear: reload 0, value 0 expires every clock
    wr(6'h10, 0); wr(6'h14, 0);
    wr(6'h00, ctl(0, 1, 1, 0, 0));
    repeat (3) @(negedge clk);
    wr(6'h04, 0);
    rd(6'h04, d); check("R11 priority", d, 32'h1);
    check("R11 irq", {31'b0, irq[0]}, 1);

    // R8: value write restarts prescaler phase (div 3 => 8 clocks)
    wr(6'h00, 0);
    wr(6'h10, 32'h0001_0000);
    wr(6'h14, 32'h0001_0000);
    wr(6'h00, ctl(0, 1, 1, 0, 3));
    repeat (5) @(negedge clk);
    bus_addr = 6'h14;
    wr(6'h14, 32'h0000_0500);
    bus_addr = 6'h14;
    repeat (7) @(posedge clk);
    #1 check("R8 before", bus_rdata, 32'h0000_0500);
    @(posedge clk);
    #1 check("R8 after", bus_rdata, 32'h0000_04FF);

    // R9 wrap through all ones
    wr(6'h00, 0); wr(6'h04, 0);
    wr(6'h10, 32'hFFFF_FFFF);
    wr(6'h14, 3);
    wr(6'h00, ctl(0, 1, 1, 0, 0));
    repeat (6) @(negedge clk);
    wr(6'h00, 0);
    rd(6'h14, d);
    check("R9 wrap", d, 32'hFFFF_FFFF - (7 - 4));
    rd(6'h04, d); check("R9 flag", d, 32'h1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule